// File: doc/BRIEF.md
# Two-Layer Pixel Overlay Mixer

This block builds one output pixel per scan position by stacking two layers over a programmable background colour. A timing generator supplies the current scan coordinates together with a `px_valid` strobe. The fetch logic upstream presents one raw pixel word per layer on the same cycle. The stream is always ready: there is no backpressure, and every valid input produces exactly one output one cycle later.

Each layer has the following settings:
- an enable;
- an inclusive rectangle, given by its first and last column and its first and last row;
- a 4-bit format code that says how the 32-bit pixel word is unpacked into 8-bit R, G and B and, for some formats, an 8-bit alpha;
- a per-channel constant alpha.

Layer 0 is the lower layer and layer 1 the upper one. The order is fixed by the index.

Only the upper layer has colour keying. It has a key enable, a 24-bit key colour and a separate per-channel alpha that applies when its unpacked colour matches the key. With that alpha programmed to zero, keyed pixels become transparent. Each covering layer is blended over what lies beneath it with `out = round((a*top + (255-a)*under)/255)` per channel.

Top module: `overlay_mixer`

## Requirements
- R1: `out_valid` equals `px_valid` delayed by one clock. Reset (synchronous, active high) clears `out_valid` and `out_rgb` to zero.
- R2: While `px_valid` is low, `out_rgb` keeps its last value, whatever the other inputs do.
- R3: A layer covers the pixel only when its enable is set and `x0 <= px_x <= x1` and `y0 <= px_y <= y1`, with both ends inclusive. A layer that does not cover the pixel has no effect. With neither layer covering, the output is `bg_rgb`.
- R4: Layer 1 is blended over the result of layer 0 over the background. An opaque layer 1 therefore hides layer 0 where they overlap.
- R5: RGB colours are packed as R in bits [23:16], G in bits [15:8] and B in bits [7:0]. This applies to `bg_rgb`, `out_rgb`, the key colour and all alpha ports. Format codes 1 to 4 carry no alpha:
  - code 1: R, G, B in pixel bits [23:16], [15:8], [7:0];
  - code 2: B, G, R in those same positions;
  - code 3: R, G, B in bits [31:24], [23:16], [15:8];
  - code 4: B, G, R in bits [31:24], [23:16], [15:8].
- R6: Format codes 5 to 8 carry a per-pixel alpha, which is used for all three channels:
  - code 5: A in [31:24], R in [23:16], G in [15:8], B in [7:0];
  - code 6: A in [31:24], B in [23:16], G in [15:8], R in [7:0];
  - code 7: R in [31:24], G in [23:16], B in [15:8], A in [7:0];
  - code 8: B in [31:24], G in [23:16], R in [15:8], A in [7:0].
  Codes 9 to 15 are decoded as code 8.
- R7: Format code 0 reads a 16-bit pixel from bits [15:0], laid out as R [15:11], G [10:5], B [4:0]. Each channel is widened to 8 bits by appending its own top bits: `{r5, r5[4:2]}`, `{g6, g6[5:4]}` and `{b5, b5[4:2]}`.
- R8: For formats without alpha, each channel uses the matching byte of the layer's constant alpha. The blend of each channel is `(a*top + (255-a)*under)` divided by 255 and rounded to nearest.
- R9: When `w1_key_en` is set and the unpacked layer-1 colour equals `w1_key`, layer 1 blends with `w1_key_alpha` in every format. Layer 0 is never keyed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Scan position and pixels are valid |
| px_x | input | COORD_W | Current column |
| px_y | input | COORD_W | Current row |
| bg_rgb | input | 24 | Background colour |
| w0_en | input | 1 | Layer 0 enable |
| w0_x0 | input | COORD_W | Layer 0 first column |
| w0_y0 | input | COORD_W | Layer 0 first row |
| w0_x1 | input | COORD_W | Layer 0 last column (inclusive) |
| w0_y1 | input | COORD_W | Layer 0 last row (inclusive) |
| w0_fmt | input | 4 | Layer 0 format code |
| w0_alpha | input | 24 | Layer 0 constant alpha per channel |
| w0_pix | input | 32 | Layer 0 raw pixel |
| w1_en | input | 1 | Layer 1 enable |
| w1_x0 | input | COORD_W | Layer 1 first column |
| w1_y0 | input | COORD_W | Layer 1 first row |
| w1_x1 | input | COORD_W | Layer 1 last column (inclusive) |
| w1_y1 | input | COORD_W | Layer 1 last row (inclusive) |
| w1_fmt | input | 4 | Layer 1 format code |
| w1_alpha | input | 24 | Layer 1 constant alpha per channel |
| w1_key_en | input | 1 | Layer 1 colour key enable |
| w1_key | input | 24 | Layer 1 key colour |
| w1_key_alpha | input | 24 | Layer 1 alpha used on key match |
| w1_pix | input | 32 | Layer 1 raw pixel |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel |

## Verification
The assertions check four things on every cycle:
- the one-cycle valid latency;
- that the output holds between valid strobes;
- the background pass-through whenever both layers are off;
- that an opaque, unkeyed upper layer in the 24-bit padded format shows its pixel unchanged.

Only the bench scenarios can show the remaining behaviour, because each depends on a concrete mix of settings:
- the per-format byte orderings and the 16-bit widening;
- rounding of partial blends;
- key matching and the rule that the lower layer is never keyed;
- the exact inclusive edges of each rectangle.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam int CH_W  = 8;
  localparam int NCH   = 3;
  localparam int RGB_W = NCH * CH_W;
  localparam int PIX_W = 32;
  localparam int FMT_W = 4;

  typedef logic [RGB_W-1:0] rgb_t;

  typedef enum logic [FMT_W-1:0] {
    FMT_P565 = 4'd0,
    FMT_XRGB = 4'd1,
    FMT_XBGR = 4'd2,
    FMT_RGBX = 4'd3,
    FMT_BGRX = 4'd4,
    FMT_ARGB = 4'd5,
    FMT_ABGR = 4'd6,
    FMT_RGBA = 4'd7,
    FMT_BGRA = 4'd8
  } fmt_e;

  // Rounded a*t + (255-a)*b over 255, using the add-high-byte trick.
  function automatic logic [CH_W-1:0] mix_ch(input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] t,
                                             input logic [CH_W-1:0] b);
    logic [15:0] v;
    logic [15:0] s;
    v = 16'(a) * 16'(t) + 16'(8'd255 - a) * 16'(b) + 16'd128;
    s = v + (v >> 8);
    return CH_W'(s >> 8);
  endfunction

endpackage

// File: rtl/ovl_hit.sv
module ovl_hit #(
  parameter int COORD_W = 12
) (
  input  logic               en,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  output logic               hit
);
  logic in_x;
  logic in_y;

  assign in_x = (x >= x0) && (x <= x1);
  assign in_y = (y >= y0) && (y <= y1);
  assign hit  = en && in_x && in_y;
endmodule

// File: rtl/ovl_unpack.sv
module ovl_unpack
  import ovl_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [FMT_W-1:0] fmt,
  output rgb_t             rgb,
  output logic [CH_W-1:0]  alpha,
  output logic             has_alpha
);
  logic [4:0] r5;
  logic [5:0] g6;
  logic [4:0] b5;

  assign r5 = pix[15:11];
  assign g6 = pix[10:5];
  assign b5 = pix[4:0];

  always_comb begin
    rgb       = '0;
    alpha     = '0;
    has_alpha = 1'b0;
    case (fmt_e'(fmt))
      FMT_P565: rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      FMT_XRGB: rgb = pix[23:0];
      FMT_XBGR: rgb = {pix[7:0], pix[15:8], pix[23:16]};
      FMT_RGBX: rgb = pix[31:8];
      FMT_BGRX: rgb = {pix[15:8], pix[23:16], pix[31:24]};
      FMT_ARGB: begin
        rgb = pix[23:0];
        alpha = pix[31:24];
        has_alpha = 1'b1;
      end
      FMT_ABGR: begin
        rgb = {pix[7:0], pix[15:8], pix[23:16]};
        alpha = pix[31:24];
        has_alpha = 1'b1;
      end
      FMT_RGBA: begin
        rgb = pix[31:8];
        alpha = pix[7:0];
        has_alpha = 1'b1;
      end
      default: begin
        rgb = {pix[15:8], pix[23:16], pix[31:24]};
        alpha = pix[7:0];
        has_alpha = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
(
  input  logic use_top,
  input  rgb_t top,
  input  rgb_t under,
  input  rgb_t alpha,
  output rgb_t result
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] mixed;
    assign mixed = mix_ch(alpha[c*CH_W +: CH_W], top[c*CH_W +: CH_W],
                          under[c*CH_W +: CH_W]);
    assign result[c*CH_W +: CH_W] = use_top ? mixed : under[c*CH_W +: CH_W];
  end
endmodule

// File: rtl/overlay_mixer.sv
module overlay_mixer
  import ovl_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               px_valid,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [23:0]        bg_rgb,
  input  logic               w0_en,
  input  logic [COORD_W-1:0] w0_x0,
  input  logic [COORD_W-1:0] w0_y0,
  input  logic [COORD_W-1:0] w0_x1,
  input  logic [COORD_W-1:0] w0_y1,
  input  logic [3:0]         w0_fmt,
  input  logic [23:0]        w0_alpha,
  input  logic [31:0]        w0_pix,
  input  logic               w1_en,
  input  logic [COORD_W-1:0] w1_x0,
  input  logic [COORD_W-1:0] w1_y0,
  input  logic [COORD_W-1:0] w1_x1,
  input  logic [COORD_W-1:0] w1_y1,
  input  logic [3:0]         w1_fmt,
  input  logic [23:0]        w1_alpha,
  input  logic               w1_key_en,
  input  logic [23:0]        w1_key,
  input  logic [23:0]        w1_key_alpha,
  input  logic [31:0]        w1_pix,
  output logic               out_valid,
  output logic [23:0]        out_rgb
);
  localparam int NWIN    = 2;
  localparam int KEY_WIN = NWIN - 1;

  logic               en_v    [NWIN];
  logic [COORD_W-1:0] x0_v    [NWIN];
  logic [COORD_W-1:0] y0_v    [NWIN];
  logic [COORD_W-1:0] x1_v    [NWIN];
  logic [COORD_W-1:0] y1_v    [NWIN];
  logic [FMT_W-1:0]   fmt_v   [NWIN];
  rgb_t               calpha_v[NWIN];
  logic [PIX_W-1:0]   pix_v   [NWIN];

  logic               hit_v   [NWIN];
  rgb_t               rgb_v   [NWIN];
  logic [CH_W-1:0]    a_v     [NWIN];
  logic               has_a_v [NWIN];
  rgb_t               alpha_v [NWIN];
  rgb_t               stage   [NWIN+1];

  assign en_v[0] = w0_en;      assign en_v[1] = w1_en;
  assign x0_v[0] = w0_x0;      assign x0_v[1] = w1_x0;
  assign y0_v[0] = w0_y0;      assign y0_v[1] = w1_y0;
  assign x1_v[0] = w0_x1;      assign x1_v[1] = w1_x1;
  assign y1_v[0] = w0_y1;      assign y1_v[1] = w1_y1;
  assign fmt_v[0] = w0_fmt;    assign fmt_v[1] = w1_fmt;
  assign calpha_v[0] = w0_alpha; assign calpha_v[1] = w1_alpha;
  assign pix_v[0] = w0_pix;    assign pix_v[1] = w1_pix;

  assign stage[0] = bg_rgb;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    ovl_hit #(.COORD_W(COORD_W)) u_hit (
      .en (en_v[g]),
      .x  (px_x),
      .y  (px_y),
      .x0 (x0_v[g]),
      .y0 (y0_v[g]),
      .x1 (x1_v[g]),
      .y1 (y1_v[g]),
      .hit(hit_v[g])
    );

    ovl_unpack u_unpack (
      .pix      (pix_v[g]),
      .fmt      (fmt_v[g]),
      .rgb      (rgb_v[g]),
      .alpha    (a_v[g]),
      .has_alpha(has_a_v[g])
    );

    if (g == KEY_WIN) begin : g_keyed
      logic key_hit;
      assign key_hit    = w1_key_en && (rgb_v[g] == w1_key);
      assign alpha_v[g] = key_hit      ? w1_key_alpha :
                          has_a_v[g]   ? {NCH{a_v[g]}} : calpha_v[g];
    end else begin : g_plain
      assign alpha_v[g] = has_a_v[g] ? {NCH{a_v[g]}} : calpha_v[g];
    end

    ovl_blend u_blend (
      .use_top(hit_v[g]),
      .top    (rgb_v[g]),
      .under  (stage[g]),
      .alpha  (alpha_v[g]),
      .result (stage[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= px_valid;
      if (px_valid) out_rgb <= stage[NWIN];
    end
  end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               px_valid,
  input logic [COORD_W-1:0] px_x,
  input logic [COORD_W-1:0] px_y,
  input logic [23:0]        bg_rgb,
  input logic               w0_en,
  input logic               w1_en,
  input logic [COORD_W-1:0] w1_x0,
  input logic [COORD_W-1:0] w1_y0,
  input logic [COORD_W-1:0] w1_x1,
  input logic [COORD_W-1:0] w1_y1,
  input logic [3:0]         w1_fmt,
  input logic [23:0]        w1_alpha,
  input logic               w1_key_en,
  input logic [31:0]        w1_pix,
  input logic               out_valid,
  input logic [23:0]        out_rgb
);
  logic top_opaque;
  assign top_opaque = w1_en && !w1_key_en && (w1_fmt == 4'd1) &&
                      (w1_alpha == 24'hFFFFFF) &&
                      (px_x >= w1_x0) && (px_x <= w1_x1) &&
                      (px_y >= w1_y0) && (px_y <= w1_y1);

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> $stable(out_rgb));

  assert_bg_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !w0_en && !w1_en) |=> (out_rgb == $past(bg_rgb)));

  assert_top_opaque_R4: assert property (@(posedge clk) disable iff (rst)
    (px_valid && top_opaque) |=> (out_rgb == $past(w1_pix[23:0])));
endmodule

bind overlay_mixer ovl_checker #(.COORD_W(COORD_W)) u_ovl_checker (
  .clk      (clk),
  .rst      (rst),
  .px_valid (px_valid),
  .px_x     (px_x),
  .px_y     (px_y),
  .bg_rgb   (bg_rgb),
  .w0_en    (w0_en),
  .w1_en    (w1_en),
  .w1_x0    (w1_x0),
  .w1_y0    (w1_y0),
  .w1_x1    (w1_x1),
  .w1_y1    (w1_y1),
  .w1_fmt   (w1_fmt),
  .w1_alpha (w1_alpha),
  .w1_key_en(w1_key_en),
  .w1_pix   (w1_pix),
  .out_valid(out_valid),
  .out_rgb  (out_rgb)
);

// File: tb/test_overlay_mixer.sv
module test_overlay_mixer;
  localparam int CW = 12;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic px_valid;
  logic [CW-1:0] px_x, px_y;
  logic [23:0] bg_rgb;
  logic w0_en, w1_en, w1_key_en;
  logic [CW-1:0] w0_x0, w0_y0, w0_x1, w0_y1;
  logic [CW-1:0] w1_x0, w1_y0, w1_x1, w1_y1;
  logic [3:0] w0_fmt, w1_fmt;
  logic [23:0] w0_alpha, w1_alpha, w1_key, w1_key_alpha;
  logic [31:0] w0_pix, w1_pix;
  logic out_valid;
  logic [23:0] out_rgb;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] last_exp;

  overlay_mixer #(.COORD_W(CW)) i_overlay_mixer (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
    .bg_rgb(bg_rgb),
    .w0_en(w0_en), .w0_x0(w0_x0), .w0_y0(w0_y0), .w0_x1(w0_x1), .w0_y1(w0_y1),
    .w0_fmt(w0_fmt), .w0_alpha(w0_alpha), .w0_pix(w0_pix),
    .w1_en(w1_en), .w1_x0(w1_x0), .w1_y0(w1_y0), .w1_x1(w1_x1), .w1_y1(w1_y1),
    .w1_fmt(w1_fmt), .w1_alpha(w1_alpha), .w1_key_en(w1_key_en),
    .w1_key(w1_key), .w1_key_alpha(w1_key_alpha), .w1_pix(w1_pix),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent reference model
  function automatic void ref_unpack(input logic [31:0] p, input logic [3:0] f,
                                     output logic [23:0] c, output int a,
                                     output bit ha);
    logic [4:0] r5, b5;
    logic [5:0] g6;
    r5 = p[15:11]; g6 = p[10:5]; b5 = p[4:0];
    a = 0; ha = 1'b1;
    case (f)
      4'd0: begin c = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]}; ha = 1'b0; end
      4'd1: begin c = {p[23:16], p[15:8], p[7:0]}; ha = 1'b0; end
      4'd2: begin c = {p[7:0], p[15:8], p[23:16]}; ha = 1'b0; end
      4'd3: begin c = {p[31:24], p[23:16], p[15:8]}; ha = 1'b0; end
      4'd4: begin c = {p[15:8], p[23:16], p[31:24]}; ha = 1'b0; end
      4'd5: begin c = p[23:0]; a = int'(p[31:24]); end
      4'd6: begin c = {p[7:0], p[15:8], p[23:16]}; a = int'(p[31:24]); end
      4'd7: begin c = p[31:8]; a = int'(p[7:0]); end
      default: begin c = {p[15:8], p[23:16], p[31:24]}; a = int'(p[7:0]); end
    endcase
  endfunction

  function automatic int ref_mix(int a, int t, int b);
    return (a * t + (255 - a) * b + 127) / 255;
  endfunction

  function automatic logic [23:0] ref_layer(
      input logic [23:0] under, input bit en, input int x, input int y,
      input int x0, input int y0, input int x1, input int y1,
      input logic [31:0] p, input logic [3:0] f, input logic [23:0] calpha,
      input bit keyed, input bit ken, input logic [23:0] key,
      input logic [23:0] kalpha);
    logic [23:0] c, al, res;
    int a;
    bit ha;
    if (!en || x < x0 || x > x1 || y < y0 || y > y1) return under;
    ref_unpack(p, f, c, a, ha);
    if (keyed && ken && c == key) al = kalpha;
    else if (ha) al = {3{a[7:0]}};
    else al = calpha;
    for (int ch = 0; ch < 3; ch++)
      res[ch*8 +: 8] = 8'(ref_mix(int'(al[ch*8 +: 8]), int'(c[ch*8 +: 8]),
                                  int'(under[ch*8 +: 8])));
    return res;
  endfunction

  function automatic logic [23:0] ref_pixel();
    logic [23:0] l0;
    l0 = ref_layer(bg_rgb, w0_en, int'(px_x), int'(px_y), int'(w0_x0),
                   int'(w0_y0), int'(w0_x1), int'(w0_y1), w0_pix, w0_fmt,
                   w0_alpha, 1'b0, 1'b0, 24'h0, 24'h0);
    return ref_layer(l0, w1_en, int'(px_x), int'(px_y), int'(w1_x0),
                     int'(w1_y0), int'(w1_x1), int'(w1_y1), w1_pix, w1_fmt,
                     w1_alpha, 1'b1, w1_key_en, w1_key, w1_key_alpha);
  endfunction

  task automatic fail_line(string tag, logic [23:0] act, logic [23:0] exp);
    n_fail++;
    $display("FAIL %s: got %06h expected %06h", tag, act, exp);
  endtask

  // Driver: presents one vector and queues its expected pixel
  task automatic apply(input int x, input int y, input string tag);
    px_x = CW'(x);
    px_y = CW'(y);
    px_valid = 1'b1;
    last_exp = ref_pixel();
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    px_valid = 1'b0;
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        fail_line("R1 unexpected out_valid", out_rgb, 24'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_rgb !== e) fail_line(t, out_rgb, e);
      end
    end
  end

  task automatic cfg_default();
    bg_rgb = 24'h000000;
    w0_en = 0; w1_en = 0; w1_key_en = 0;
    w0_x0 = 0; w0_y0 = 0; w0_x1 = 0; w0_y1 = 0;
    w1_x0 = 0; w1_y0 = 0; w1_x1 = 0; w1_y1 = 0;
    w0_fmt = 4'd1; w1_fmt = 4'd1;
    w0_alpha = 24'hFFFFFF; w1_alpha = 24'hFFFFFF;
    w1_key = 24'h0; w1_key_alpha = 24'h000000;
    w0_pix = 32'h0; w1_pix = 32'h0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R1 watchdog expired: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; px_valid = 1'b0; px_x = 0; px_y = 0;
    cfg_default();
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0)
      fail_line("R1 reset state", {out_valid, out_rgb[22:0]}, 24'h0);
    rst = 1'b0;
    @(negedge clk);

    // R3: nothing enabled -> background
    bg_rgb = 24'h123456;
    apply(5, 5, "R3 background");
    // R3/R5: layer 0 xRGB, opaque, edges inclusive
    w0_en = 1; w0_x0 = 10; w0_y0 = 20; w0_x1 = 19; w0_y1 = 29;
    w0_pix = 32'h00A1B2C3;
    apply(10, 20, "R3 top-left inside");
    apply(19, 29, "R3 bottom-right inside");
    apply(20, 29, "R3 right of edge");
    apply(19, 30, "R3 below edge");
    apply(9, 25, "R3 left of edge");
    w0_en = 0;
    apply(15, 25, "R3 disabled layer");
    w0_en = 1;

    // R5/R6: every format code on layer 0
    w0_pix = 32'hC4803A11;
    for (int f = 0; f < 16; f++) begin
      w0_fmt = 4'(f);
      apply(12, 22, (f == 0) ? "R7 rgb565" : (f < 5) ? "R5 format" : "R6 format");
    end
    // R7: 565 extremes
    w0_fmt = 4'd0;
    w0_pix = 32'h0000F800; apply(12, 22, "R7 565 red max");
    w0_pix = 32'h000007E0; apply(12, 22, "R7 565 green max");
    w0_pix = 32'h00000841; apply(12, 22, "R7 565 low bits");

    // R8: constant alpha per channel over background
    w0_fmt = 4'd1; w0_pix = 32'h00FF8040; bg_rgb = 24'h2080C0;
    w0_alpha = 24'h8040C0;
    apply(12, 22, "R8 constant alpha blend");
    w0_alpha = 24'h000000;
    apply(12, 22, "R8 zero alpha");
    w0_alpha = 24'hFFFFFF;

    // R4: layer 1 over layer 0
    w1_en = 1; w1_x0 = 15; w1_y0 = 25; w1_x1 = 16; w1_y1 = 26;
    w1_fmt = 4'd1; w1_pix = 32'h00112233;
    apply(15, 25, "R4 opaque top hides bottom");
    apply(14, 25, "R4 bottom only beside top");
    w1_fmt = 4'd5; w1_pix = 32'h40FF00FF;
    apply(16, 26, "R4 per-pixel alpha over bottom");

    // R9: colour key on layer 1
    w1_fmt = 4'd1; w1_pix = 32'h00ABCDEF; w1_key = 24'hABCDEF; w1_key_en = 1;
    apply(15, 25, "R9 key match transparent");
    w1_key_alpha = 24'h80FF10;
    apply(15, 25, "R9 key match key alpha");
    w1_key = 24'hABCDEE;
    apply(15, 25, "R9 key mismatch");
    w1_fmt = 4'd7; w1_pix = 32'hABCDEF20; w1_key = 24'hABCDEF;
    apply(15, 25, "R9 key overrides pixel alpha");
    w1_en = 0; w0_fmt = 4'd1; w0_pix = 32'h00ABCDEF;
    apply(15, 25, "R9 bottom layer not keyed");

    // R2: output holds while idle
    w1_en = 1; w1_key_en = 0; w1_fmt = 4'd1; w1_pix = 32'h00778899;
    apply(15, 25, "R2 setup");
    for (int i = 0; i < 3; i++) begin
      w1_pix = 32'(i * 32'h01010101); bg_rgb = 24'(i * 7); px_x = CW'(i);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || out_rgb !== last_exp)
        fail_line("R2 hold while idle", out_rgb, last_exp);
    end

    // Mixed random vectors
    for (int i = 0; i < 400; i++) begin
      bg_rgb = 24'($urandom);
      w0_en = 1'($urandom); w1_en = 1'($urandom); w1_key_en = 1'($urandom);
      w0_x0 = CW'($urandom % 8); w0_x1 = CW'(4 + $urandom % 10);
      w0_y0 = CW'($urandom % 8); w0_y1 = CW'(4 + $urandom % 10);
      w1_x0 = CW'($urandom % 8); w1_x1 = CW'(4 + $urandom % 10);
      w1_y0 = CW'($urandom % 8); w1_y1 = CW'(4 + $urandom % 10);
      w0_fmt = 4'($urandom); w1_fmt = 4'($urandom);
      w0_alpha = 24'($urandom); w1_alpha = 24'($urandom);
      w1_key_alpha = 24'($urandom);
      w0_pix = $urandom; w1_pix = $urandom;
      w1_key = ($urandom % 2 == 1) ? w1_pix[23:0] : 24'($urandom);
      apply(int'($urandom % 16), int'($urandom % 16), "R4 R8 R9 mixed");
      if (i % 7 == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0)
      fail_line("R1 missing outputs", 24'(exp_q.size()), 24'h0);
    summary();
    $finish;
  end
endmodule